// File: doc/BRIEF.md
# Mode-Banked Register File

A processor register file of sixteen 32-bit general registers in which part of the register set is swapped for per-mode copies, according to a 5-bit processor mode held inside the block. Registers r0–r7 and the program counter (r15) are shared by every mode. The fast-interrupt mode has its own copies of r8–r14. The interrupt, supervisor, abort and undefined modes have their own r13 and r14 only, and they use the user copies of r8–r12. A mode value with no bank of its own selects a dummy bank whose r8–r14 read as zero and do not accept writes.

The datapath sees two combinational read ports and one write port, all resolved in the current mode. A fourth port names any mode explicitly and reads or writes that mode's copy of a register. A debug or context-switch engine can use it to reach a suspended mode's stack pointer and link register without changing mode. A mode change is a one-cycle load of the mode register. Every copy sits in its own physical slot, so no registers move when the mode changes.

Top module: `banked_regfile`

## Requirements
- R1: Reset, asserted asynchronously by a low on rst_ni, sets the current mode to 19 (32-bit supervisor) and clears every register copy to zero.
- R2: Read ports A and B return the current-mode copy of the indexed register combinationally. A write on the write port is seen at the read ports from the cycle after the clock edge that takes it.
- R3: The mode decodes to a bank as follows: 0 and 16 → user, 1 and 17 → fast interrupt, 2 and 18 → interrupt, 3 and 19 → supervisor, 23 → abort, 27 → undefined. Every other value up to 27 → dummy.
- R4: Any mode value above 27 selects the dummy bank.
- R5: The fast-interrupt bank has its own copies of r8–r14, separate from every other bank.
- R6: The interrupt, supervisor, abort and undefined banks have their own r13 and r14 and share r8–r12 with user mode. r0–r7 and r15 are one copy shared by all modes, the dummy bank included.
- R7: In the dummy bank, r8–r14 read as zero on every read port, and writes to them change no stored register.
- R8: The other-mode port reads or writes the copy of xm_idx_i that belongs to the bank of xm_mode_i. When that bank is the current bank, it reaches the same copy that the current-mode ports see.
- R9: When mode_set_i is high, mode_new_i is loaded at the clock edge and takes effect from the next cycle. A write in that same cycle uses the old mode. A change between two modes of the same bank leaves all register contents unchanged.
- R10: If the write port and the other-mode write port hit the same physical copy in the same cycle, the write port's data is stored. Writes to different copies in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_set_i | input | 1 | Load mode_new_i into the mode register |
| mode_new_i | input | 5 | New processor mode |
| mode_o | output | 5 | Current processor mode |
| rd_a_idx_i | input | 4 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Current-mode write enable |
| wr_idx_i | input | 4 | Current-mode write index |
| wr_data_i | input | 32 | Current-mode write data |
| xm_we_i | input | 1 | Other-mode port write enable |
| xm_mode_i | input | 5 | Mode named by the other-mode port |
| xm_idx_i | input | 4 | Other-mode port register index |
| xm_wdata_i | input | 32 | Other-mode port write data |
| xm_rdata_o | output | 32 | Other-mode port read data |

## Verification
A wrong slot mapping shows at the ports as soon as a value written in one mode is read back in another. Examples: a fast-interrupt r8 that aliases the user r8, or an abort r13 that lands in the supervisor slot. The read ports are combinational, so the wrong value appears in the first cycle after the write and the mode change. A stale or mis-decoded mode register shows on mode_o in the cycle after the load, and it shows in the data of every banked index. A faulty dummy gate shows as non-zero data on r8–r14, or as a user register that changes after a write made in an invalid mode.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
  localparam int MODE_W    = 5;
  localparam int IDX_W     = 4;
  localparam int SLOT_W    = 5;
  // r0-r7, user r8-r12, fiq r8-r12, six r13/r14 pairs, r15
  localparam int LOW_N     = 8;
  localparam int SHARE_N   = 5;
  localparam int PAIR_BASE = LOW_N + 2 * SHARE_N;
  localparam int NUM_BANKS = 6;
  localparam int PC_SLOT   = PAIR_BASE + 2 * NUM_BANKS;
  localparam int NUM_SLOTS = PC_SLOT + 1;
  localparam logic [MODE_W-1:0] RESET_MODE = 5'd19;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5,
    BK_DUM = 3'd6
  } bank_e;

  function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
    bank_e b;
    case (m)
      5'd0,  5'd16: b = BK_USR;
      5'd1,  5'd17: b = BK_FIQ;
      5'd2,  5'd18: b = BK_IRQ;
      5'd3,  5'd19: b = BK_SVC;
      5'd23:        b = BK_ABT;
      5'd27:        b = BK_UND;
      default:      b = BK_DUM;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/rf_bank_decode.sv
module rf_bank_decode
  import banked_rf_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o
);
  // values above 27 fall into the default arm
  assign bank_o = bank_of(mode_i);
endmodule

// File: rtl/rf_slot_map.sv
module rf_slot_map
  import banked_rf_pkg::*;
(
  input  bank_e             bank_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              hit_o
);
  localparam logic [IDX_W-1:0] PC_IDX  = IDX_W'(15);
  localparam logic [IDX_W-1:0] LAST_SH = IDX_W'(LOW_N + SHARE_N - 1);
  localparam logic [IDX_W-1:0] SP_IDX  = IDX_W'(LOW_N + SHARE_N);

  always_comb begin
    slot_o = '0;
    hit_o  = 1'b1;
    if (idx_i < IDX_W'(LOW_N)) begin
      slot_o = SLOT_W'(idx_i);
    end else if (idx_i == PC_IDX) begin
      slot_o = SLOT_W'(PC_SLOT);
    end else if (bank_i == BK_DUM) begin
      hit_o = 1'b0;
    end else if (idx_i <= LAST_SH) begin
      slot_o = (bank_i == BK_FIQ) ? SLOT_W'(idx_i) + SLOT_W'(SHARE_N)
                                  : SLOT_W'(idx_i);
    end else begin
      slot_o = SLOT_W'(PAIR_BASE) + SLOT_W'({bank_i, 1'b0})
             + SLOT_W'(idx_i - SP_IDX);
    end
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 31,
  parameter int SLOT_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wa_en_i,
  input  logic [SLOT_W-1:0] wa_slot_i,
  input  logic [DATA_W-1:0] wa_data_i,
  input  logic              wb_en_i,
  input  logic [SLOT_W-1:0] wb_slot_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic [SLOT_W-1:0] ra_slot_i,
  output logic [DATA_W-1:0] ra_o,
  input  logic [SLOT_W-1:0] rb_slot_i,
  output logic [DATA_W-1:0] rb_o,
  input  logic [SLOT_W-1:0] rc_slot_i,
  output logic [DATA_W-1:0] rc_o
);
  logic [DATA_W-1:0] q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q[g] <= '0;
      end else if (wa_en_i && wa_slot_i == SLOT_W'(g)) begin
        q[g] <= wa_data_i;  // port A has priority
      end else if (wb_en_i && wb_slot_i == SLOT_W'(g)) begin
        q[g] <= wb_data_i;
      end
    end
  end

  always_comb begin
    ra_o = '0;
    rb_o = '0;
    rc_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (ra_slot_i == SLOT_W'(i)) ra_o = q[i];
      if (rb_slot_i == SLOT_W'(i)) rb_o = q[i];
      if (rc_slot_i == SLOT_W'(i)) rc_o = q[i];
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_set_i,
  input  logic [4:0]        mode_new_i,
  output logic [4:0]        mode_o,
  input  logic [3:0]        rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              xm_we_i,
  input  logic [4:0]        xm_mode_i,
  input  logic [3:0]        xm_idx_i,
  input  logic [DATA_W-1:0] xm_wdata_i,
  output logic [DATA_W-1:0] xm_rdata_o
);
  logic [MODE_W-1:0] mode_q;
  bank_e cur_bank, xm_bank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mode_q <= RESET_MODE;
    else if (mode_set_i) mode_q <= mode_new_i;
  end
  assign mode_o = mode_q;

  rf_bank_decode u_dec_cur (.mode_i(mode_q),    .bank_o(cur_bank));
  rf_bank_decode u_dec_xm  (.mode_i(xm_mode_i), .bank_o(xm_bank));

  logic [SLOT_W-1:0] ra_slot, rb_slot, w_slot, x_slot;
  logic              ra_hit, rb_hit, w_hit, x_hit;
  logic [DATA_W-1:0] ra_q, rb_q, x_q;

  rf_slot_map u_map_ra (.bank_i(cur_bank), .idx_i(rd_a_idx_i), .slot_o(ra_slot), .hit_o(ra_hit));
  rf_slot_map u_map_rb (.bank_i(cur_bank), .idx_i(rd_b_idx_i), .slot_o(rb_slot), .hit_o(rb_hit));
  rf_slot_map u_map_w  (.bank_i(cur_bank), .idx_i(wr_idx_i),   .slot_o(w_slot),  .hit_o(w_hit));
  rf_slot_map u_map_x  (.bank_i(xm_bank),  .idx_i(xm_idx_i),   .slot_o(x_slot),  .hit_o(x_hit));

  rf_storage #(
    .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wa_en_i  (wr_en_i && w_hit),
    .wa_slot_i(w_slot),
    .wa_data_i(wr_data_i),
    .wb_en_i  (xm_we_i && x_hit),
    .wb_slot_i(x_slot),
    .wb_data_i(xm_wdata_i),
    .ra_slot_i(ra_slot),
    .ra_o     (ra_q),
    .rb_slot_i(rb_slot),
    .rb_o     (rb_q),
    .rc_slot_i(x_slot),
    .rc_o     (x_q)
  );

  assign rd_a_data_o = ra_hit ? ra_q : '0;
  assign rd_b_data_o = rb_hit ? rb_q : '0;
  assign xm_rdata_o  = x_hit  ? x_q  : '0;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_set_i,
  input logic [4:0]        mode_new_i,
  input logic [4:0]        mode_o,
  input logic [3:0]        rd_a_idx_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [3:0]        rd_b_idx_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic              wr_en_i,
  input logic [3:0]        wr_idx_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [3:0]        xm_idx_i,
  input logic [DATA_W-1:0] xm_rdata_o
);
  logic cur_dummy;
  assign cur_dummy = (bank_of(mode_o) == BK_DUM);

  // R9
  mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_set_i |=> mode_o == $past(mode_new_i));

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_set_i |=> $stable(mode_o));

  // R7
  dummy_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_dummy && rd_a_idx_i >= 4'd8 && rd_a_idx_i <= 4'd14) |-> rd_a_data_o == '0);

  // R4
  high_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o > 5'd27 && rd_b_idx_i >= 4'd8 && rd_b_idx_i <= 4'd14) |-> rd_b_data_o == '0);

  // R2
  low_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i < 4'd8) |=>
      ((rd_a_idx_i == $past(wr_idx_i)) -> rd_a_data_o == $past(wr_data_i)));

  // R6
  shared_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xm_idx_i == rd_b_idx_i && (xm_idx_i < 4'd8 || xm_idx_i == 4'd15))
      |-> xm_rdata_o == rd_b_data_o);
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_set_i (mode_set_i),
  .mode_new_i (mode_new_i),
  .mode_o     (mode_o),
  .rd_a_idx_i (rd_a_idx_i),
  .rd_a_data_o(rd_a_data_o),
  .rd_b_idx_i (rd_b_idx_i),
  .rd_b_data_o(rd_b_data_o),
  .wr_en_i    (wr_en_i),
  .wr_idx_i   (wr_idx_i),
  .wr_data_i  (wr_data_i),
  .xm_idx_i   (xm_idx_i),
  .xm_rdata_o (xm_rdata_o)
);

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int N = 48;
  localparam logic [1:0] OP_MODE = 2'd0, OP_WR = 2'd1, OP_CHK = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  mode;
    logic [3:0]  idx;
    logic [31:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam logic [31:0] V_SV13 = 32'h0000_A113, V_U8 = 32'h0000_B008,
    V_F8 = 32'hF008_0000, V_F13 = 32'hF013_0000, V_I14 = 32'h1E14_0000,
    V_A13 = 32'hAB13_0000, V_UD13 = 32'h0D13_0000, V_JUNK = 32'h9999_9999,
    V_R3 = 32'h3333_0003, V_PC = 32'h0000_1F00;

  localparam vec_t TBL [N] = '{
    {OP_WR,   5'd0,  4'd13, V_SV13, 4'd0},
    {OP_WR,   5'd0,  4'd8,  V_U8,   4'd0},
    {OP_MODE, 5'd17, 4'd0,  32'h0,  4'd0},
    {OP_CHK,  5'd0,  4'd13, 32'h0,  4'd5},  // R5
    {OP_CHK,  5'd0,  4'd8,  32'h0,  4'd5},  // R5
    {OP_WR,   5'd0,  4'd8,  V_F8,   4'd0},
    {OP_WR,   5'd0,  4'd13, V_F13,  4'd0},
    {OP_MODE, 5'd16, 4'd0,  32'h0,  4'd0},
    {OP_CHK,  5'd0,  4'd8,  V_U8,   4'd6},  // R6
    {OP_CHK,  5'd0,  4'd13, 32'h0,  4'd6},  // R6
    {OP_WR,   5'd0,  4'd15, V_PC,   4'd0},
    {OP_MODE, 5'd18, 4'd0,  32'h0,  4'd0},
    {OP_CHK,  5'd0,  4'd8,  V_U8,   4'd6},  // R6
    {OP_WR,   5'd0,  4'd14, V_I14,  4'd0},
    {OP_CHK,  5'd0,  4'd15, V_PC,   4'd6},  // R6
    {OP_MODE, 5'd3,  4'd0,  32'h0,  4'd0},
    {OP_CHK,  5'd0,  4'd13, V_SV13, 4'd3},  // R3
    {OP_CHK,  5'd0,  4'd14, 32'h0,  4'd6},  // R6
    {OP_MODE, 5'd1,  4'd0,  32'h0,  4'd0},
    {OP_CHK,  5'd0,  4'd8,  V_F8,   4'd3},  // R3
    {OP_CHK,  5'd0,  4'd13, V_F13,  4'd5},  // R5
    {OP_CHK,  5'd0,  4'd15, V_PC,   4'd6},  // R6
    {OP_MODE, 5'd23, 4'd0,  32'h0,  4'd0},
    {OP_CHK,  5'd0,  4'd13, 32'h0,  4'd3},  // R3
    {OP_WR,   5'd0,  4'd13, V_A13,  4'd0},
    {OP_CHK,  5'd0,  4'd13, V_A13,  4'd3},  // R3
    {OP_MODE, 5'd27, 4'd0,  32'h0,  4'd0},
    {OP_CHK,  5'd0,  4'd13, 32'h0,  4'd3},  // R3
    {OP_WR,   5'd0,  4'd13, V_UD13, 4'd0},
    {OP_CHK,  5'd0,  4'd13, V_UD13, 4'd3},  // R3
    {OP_MODE, 5'd5,  4'd0,  32'h0,  4'd0},
    {OP_CHK,  5'd0,  4'd8,  32'h0,  4'd7},  // R7
    {OP_WR,   5'd0,  4'd8,  V_JUNK, 4'd0},
    {OP_CHK,  5'd0,  4'd8,  32'h0,  4'd7},  // R7
    {OP_WR,   5'd0,  4'd3,  V_R3,   4'd0},
    {OP_CHK,  5'd0,  4'd3,  V_R3,   4'd6},  // R6
    {OP_MODE, 5'd30, 4'd0,  32'h0,  4'd0},
    {OP_CHK,  5'd0,  4'd13, 32'h0,  4'd4},  // R4
    {OP_CHK,  5'd0,  4'd14, 32'h0,  4'd4},  // R4
    {OP_MODE, 5'd23, 4'd0,  32'h0,  4'd0},
    {OP_CHK,  5'd0,  4'd13, V_A13,  4'd3},  // R3
    {OP_MODE, 5'd0,  4'd0,  32'h0,  4'd0},
    {OP_CHK,  5'd0,  4'd8,  V_U8,   4'd7},  // R7
    {OP_MODE, 5'd16, 4'd0,  32'h0,  4'd0},
    {OP_CHK,  5'd0,  4'd8,  V_U8,   4'd9},  // R9
    {OP_CHK,  5'd0,  4'd14, 32'h0,  4'd9},  // R9
    {OP_MODE, 5'd2,  4'd0,  32'h0,  4'd0},
    {OP_CHK,  5'd0,  4'd14, V_I14,  4'd3}   // R3
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_set_i = 1'b0;
  logic [4:0]  mode_new_i = '0;
  logic [4:0]  mode_o;
  logic [3:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0, xm_idx_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, xm_rdata_o;
  logic        wr_en_i = 1'b0, xm_we_i = 1'b0;
  logic [31:0] wr_data_i = '0, xm_wdata_i = '0;
  logic [4:0]  xm_mode_i = '0;

  int n_checks = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  banked_regfile u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .mode_set_i(mode_set_i), .mode_new_i(mode_new_i), .mode_o(mode_o),
    .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
    .rd_b_idx_i(rd_b_idx_i), .rd_b_data_o(rd_b_data_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .xm_we_i(xm_we_i), .xm_mode_i(xm_mode_i), .xm_idx_i(xm_idx_i),
    .xm_wdata_i(xm_wdata_i), .xm_rdata_o(xm_rdata_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input logic [4:0] m);
    mode_set_i = 1'b1; mode_new_i = m;
    edge_step();
    mode_set_i = 1'b0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = d;
    edge_step();
    wr_en_i = 1'b0;
  endtask

  task automatic xwr(input logic [4:0] m, input logic [3:0] idx, input logic [31:0] d);
    xm_we_i = 1'b1; xm_mode_i = m; xm_idx_i = idx; xm_wdata_i = d;
    edge_step();
    xm_we_i = 1'b0;
  endtask

  function automatic logic [31:0] dummy_fn(input logic [31:0] v);
    return v;
  endfunction

  task automatic xrd_chk(input string tag, input logic [4:0] m, input logic [3:0] idx,
                         input logic [31:0] exp);
    xm_mode_i = m; xm_idx_i = idx;
    #1;
    chk(tag, xm_rdata_o, exp);
  endtask

  task automatic rda_chk(input string tag, input logic [3:0] idx, input logic [31:0] exp);
    rd_a_idx_i = idx;
    #1;
    chk(tag, rd_a_data_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    // R1: reset state
    chk("R1 mode in reset", {27'd0, mode_o}, 32'd19);
    rst_ni = 1'b1;
    edge_step();
    for (int i = 0; i < 16; i++) begin
      rda_chk($sformatf("R1 reg %0d after reset", i), 4'(i), 32'h0);
    end
    xrd_chk("R1 fiq r8 after reset", 5'd17, 4'd8, 32'h0);

    // table walk
    for (int i = 0; i < N; i++) begin
      case (TBL[i].op)
        OP_MODE: set_mode(TBL[i].mode);
        OP_WR:   wr(TBL[i].idx, TBL[i].val);
        default: rda_chk($sformatf("R%0d table row %0d", TBL[i].req, i), TBL[i].idx, TBL[i].val);
      endcase
    end
    // mode is 2 (interrupt bank) here

    // R8: other-mode port
    xrd_chk("R8 read fiq r8 from irq", 5'd17, 4'd8, V_F8);
    xrd_chk("R8 read current mode r14", 5'd2, 4'd14, V_I14);
    xrd_chk("R8 read same-bank mode r14", 5'd18, 4'd14, V_I14);
    xrd_chk("R7 dummy via other-mode port", 5'd24, 4'd9, 32'h0);
    xwr(5'd19, 4'd14, 32'h5A5A_0000);
    xrd_chk("R8 svc r14 written remotely", 5'd19, 4'd14, 32'h5A5A_0000);
    rda_chk("R8 live irq r14 untouched", 4'd14, V_I14);
    xwr(5'd31, 4'd10, 32'h0000_0001);
    xrd_chk("R7 dummy write via other-mode port", 5'd31, 4'd10, 32'h0);
    xrd_chk("R7 user r10 untouched", 5'd16, 4'd10, 32'h0);

    // R10: write conflict on the same copy
    wr_en_i = 1'b1; wr_idx_i = 4'd14; wr_data_i = 32'hAAAA_0000;
    xm_we_i = 1'b1; xm_mode_i = 5'd18; xm_idx_i = 4'd14; xm_wdata_i = 32'hBBBB_0000;
    edge_step();
    wr_en_i = 1'b0; xm_we_i = 1'b0;
    rda_chk("R10 write port wins", 4'd14, 32'hAAAA_0000);
    wr_en_i = 1'b1; wr_idx_i = 4'd14; wr_data_i = 32'hCCCC_0000;
    xm_we_i = 1'b1; xm_mode_i = 5'd17; xm_idx_i = 4'd14; xm_wdata_i = 32'hDDDD_0000;
    edge_step();
    wr_en_i = 1'b0; xm_we_i = 1'b0;
    rda_chk("R10 distinct copies write port", 4'd14, 32'hCCCC_0000);
    xrd_chk("R10 distinct copies other port", 5'd17, 4'd14, 32'hDDDD_0000);

    // R9: mode change with write in same cycle uses old mode
    mode_set_i = 1'b1; mode_new_i = 5'd17;
    wr_en_i = 1'b1; wr_idx_i = 4'd13; wr_data_i = 32'h7777_0000;
    #1;
    chk("R9 mode before edge", {27'd0, mode_o}, 32'd2);
    edge_step();
    mode_set_i = 1'b0; wr_en_i = 1'b0;
    chk("R9 mode after edge", {27'd0, mode_o}, 32'd17);
    rda_chk("R9 fiq r13 not hit", 4'd13, V_F13);
    xrd_chk("R9 irq r13 took write", 5'd18, 4'd13, 32'h7777_0000);

    // R2: port B and write timing
    rd_b_idx_i = 4'd8;
    #1;
    chk("R2 port B fiq r8", rd_b_data_o, dummy_fn(V_F8));
    wr_en_i = 1'b1; wr_idx_i = 4'd9; wr_data_i = 32'h4242_0000;
    rd_b_idx_i = 4'd9;
    #1;
    chk("R2 old value before edge", rd_b_data_o, 32'h0);
    edge_step();
    wr_en_i = 1'b0;
    chk("R2 new value after edge", rd_b_data_o, 32'h4242_0000);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset mode", {27'd0, mode_o}, 32'd19);
    rda_chk("R1 async reset clears svc r13", 4'd13, 32'h0);
    xrd_chk("R1 async reset clears fiq r8", 5'd17, 4'd8, 32'h0);
    @(posedge clk);
    #2;
    rst_ni = 1'b1;
    edge_step();

    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule